// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two 32-bit integers for a RISC-V style core. A two-bit operation code selects one of four operations: signed quotient, unsigned quotient, signed remainder or unsigned remainder. The caller presents both operands together with the code and raises `start` for one cycle. The unit takes the operands and works on them for a fixed number of cycles, then raises `done` for one cycle with the answer on `result`.

All four operations share one shift-subtract-restore datapath. That datapath works on operand magnitudes and handles one quotient bit per clock. A final stage applies the sign rules for the signed forms. The same final stage also substitutes the architecturally defined answers for a zero divisor. The case of the most negative value divided by minus one needs no special handling and gives its defined answer from the normal path. The unit takes no new operation until the current one has finished.

Top module: `rvdiv_unit`

## Requirements
- R1: With `op_sel` = 2'b00, `result` is the signed quotient of `dividend` by `divisor`, rounded toward zero.
- R2: With `op_sel` = 2'b01, `result` is the quotient of both operands read as unsigned numbers.
- R3: With `op_sel` = 2'b10, `result` is the signed remainder, which is zero or has the sign of `dividend`.
- R4: With `op_sel` = 2'b11, `result` is the unsigned remainder, and it is below `divisor` whenever `divisor` is nonzero.
- R5: When `divisor` is zero, both quotient codes return 32'hFFFF_FFFF and both remainder codes return `dividend` unchanged.
- R6: With signed codes, a dividend of 32'h8000_0000 divided by 32'hFFFF_FFFF gives a quotient of 32'h8000_0000 and a remainder of zero.
- R7: `done` is high for exactly one cycle, 33 rising edges after the edge that accepts `start`. `result` keeps its value until the next `done`.
- R8: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and falls in the same cycle that `done` rises. A `start` while `busy` is high is ignored and does not change the running operation.
- R9: After a synchronous active-low reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; accepted when `busy` is low |
| op_sel | input | 2 | 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder |
| dividend | input | 32 | First operand |
| divisor | input | 32 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 32 | Quotient or remainder of the last completed operation |

## Verification
The assertions assume the operation code and operands are valid in the cycle that `start` is accepted. After that they assume nothing about the inputs, because the unit latches everything it needs on that edge. The checker latches its own copy of the operands at acceptance and uses that copy when it checks the answer at `done`. For this reason the bench changes the operand pins while an operation is running, and it also pulses `start` in the middle of a run, to show that neither disturbs the outcome. The bench drives operands only on falling edges, one operation at a time. It covers the zero-divisor and overflow corners, sign combinations and random values against a model built on wide signed integers.

// File: rtl/rvdiv_pkg.sv
// Shared types for the divide unit.
// Assumes: operation code bit 0 selects unsigned, bit 1 selects remainder.
package rvdiv_pkg;

    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_DIVU = 2'b01,
        OP_REM  = 2'b10,
        OP_REMU = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10
    } div_state_e;

    // Per-operation flags captured when an operation is accepted
    typedef struct packed {
        logic neg_quo;   // quotient magnitude must be negated
        logic neg_rem;   // remainder magnitude must be negated
        logic div_zero;  // divisor was zero
        logic want_rem;  // caller asked for the remainder
    } div_flags_t;

endpackage

// File: rtl/rvdiv_operand_prep.sv
// Operand preparation: turns raw operands into magnitudes and sign flags.
// Assumes: purely combinational; inputs are the values present when the
// operation is accepted. The most negative value maps to itself as an unsigned
// magnitude, which the datapath handles correctly.
module rvdiv_operand_prep
    import rvdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output div_flags_t   flags
);

    logic is_signed;
    logic a_neg;
    logic b_neg;

    // Derive signs and magnitudes from the operation code
    always_comb begin
        is_signed      = ~op[0];
        a_neg          = is_signed & a[W-1];
        b_neg          = is_signed & b[W-1];
        mag_a          = a_neg ? (~a + 1'b1) : a;
        mag_b          = b_neg ? (~b + 1'b1) : b;
        flags.neg_quo  = a_neg ^ b_neg;
        flags.neg_rem  = a_neg;
        flags.div_zero = (b == '0);
        flags.want_rem = op[1];
    end

endmodule

// File: rtl/rvdiv_iter_core.sv
// Restoring division datapath: one quotient bit per enabled cycle.
// Assumes: load and step are never high together; after W steps following a
// load, quo holds floor(a/b) and rem holds a mod b for unsigned magnitudes.
module rvdiv_iter_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    logic [W-1:0] quo_r;
    logic [W-1:0] rem_r;
    logic [W-1:0] den_r;
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic         fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem_r, quo_r[W-1]};
        trial   = shifted - {1'b0, den_r};
        fits    = ~trial[W];
    end

    // Load operands or perform one shift-subtract-restore step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            den_r <= '0;
        end else if (load) begin
            quo_r <= mag_a;
            rem_r <= '0;
            den_r <= mag_b;
        end else if (step) begin
            quo_r <= {quo_r[W-2:0], fits};
            rem_r <= fits ? trial[W-1:0] : shifted[W-1:0];
        end
    end

    assign quo = quo_r;
    assign rem = rem_r;

endmodule

// File: rtl/rvdiv_result_fix.sv
// Result correction: applies sign rules and the zero-divisor substitutions.
// Assumes: combinational; quo/rem are final unsigned magnitudes; raw_a is the
// dividend as originally presented.
module rvdiv_result_fix
    import rvdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] raw_a,
    input  div_flags_t   flags,
    output logic [W-1:0] res
);

    logic [W-1:0] quo_s;
    logic [W-1:0] rem_s;

    // Choose the signed-corrected value or the zero-divisor answer
    always_comb begin
        quo_s = flags.neg_quo ? (~quo + 1'b1) : quo;
        rem_s = flags.neg_rem ? (~rem + 1'b1) : rem;
        if (flags.div_zero)
            res = flags.want_rem ? raw_a : '1;
        else
            res = flags.want_rem ? rem_s : quo_s;
    end

endmodule

// File: rtl/rvdiv_unit.sv
// Top of the divide unit: accepts a request, sequences W datapath steps, then
// registers the corrected answer and pulses done.
// Assumes: op_sel and operands are valid in the cycle start is accepted;
// start while busy is ignored. Latency is W+1 edges from acceptance.
module rvdiv_unit
    import rvdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int CNT_W = $clog2(W);

    div_state_e       state;
    logic [CNT_W-1:0] step_cnt;
    logic             accept;
    logic             step_en;
    logic [W-1:0]     mag_a;
    logic [W-1:0]     mag_b;
    div_flags_t       flags_in;
    div_flags_t       flags_q;
    logic [W-1:0]     raw_a_q;
    logic [W-1:0]     quo;
    logic [W-1:0]     rem;
    logic [W-1:0]     fixed;
    logic             done_q;
    logic [W-1:0]     result_q;

    assign accept  = start && (state == ST_IDLE);
    assign step_en = (state == ST_RUN);

    rvdiv_operand_prep #(.W(W)) u_prep (
        .op    (op_sel),
        .a     (dividend),
        .b     (divisor),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .flags (flags_in)
    );

    rvdiv_iter_core #(.W(W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .step         (step_en),
        .mag_a        (mag_a),
        .mag_b        (mag_b),
        .quo          (quo),
        .rem          (rem)
    );

    rvdiv_result_fix #(.W(W)) u_fix (
        .quo   (quo),
        .rem   (rem),
        .raw_a (raw_a_q),
        .flags (flags_q),
        .res   (fixed)
    );

    // Sequence idle -> W steps -> correction cycle -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_RUN;
                    step_cnt <= '0;
                end
                ST_RUN: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == CNT_W'(W - 1))
                        state <= ST_FIX;
                end
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture per-operation flags and the raw dividend on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            raw_a_q <= '0;
        end else if (accept) begin
            flags_q <= flags_in;
            raw_a_q <= dividend;
        end
    end

    // Register the corrected answer and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= (state == ST_FIX);
            if (state == ST_FIX)
                result_q <= fixed;
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/rvdiv_unit_chk.sv
// Checker for the divide unit, bound to the top. Keeps its own copy of the
// accepted request and an edge counter to check latency and corner answers.
// Assumes: inputs valid in the accepting cycle only.
module rvdiv_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op_sel,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    localparam int DONE_AT = W + 2;
    localparam int CW      = $clog2(W + 3);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [1:0]   op_l;
    logic [W-1:0] a_l;
    logic [W-1:0] b_l;
    logic [CW-1:0] edge_cnt;
    logic          acc;

    assign acc = start && !busy;

    // Latch the accepted request and count edges since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_l     <= '0;
            a_l      <= '0;
            b_l      <= '0;
            edge_cnt <= '0;
        end else begin
            if (acc) begin
                op_l     <= op_sel;
                a_l      <= dividend;
                b_l      <= divisor;
                edge_cnt <= CW'(1);
            end else if (edge_cnt == CW'(DONE_AT))
                edge_cnt <= '0;
            else if (edge_cnt != '0)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (edge_cnt == CW'(DONE_AT)));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    zero_div_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_l == '0 && !op_l[1]) |-> (result == '1));
    // R5
    zero_div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_l == '0 && op_l[1]) |-> (result == a_l));
    // R6
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_l[0] && a_l == MOST_NEG && b_l == '1)
        |-> (result == (op_l[1] ? '0 : MOST_NEG)));
    // R3
    rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l == 2'b10 && b_l != '0)
        |-> (result == '0 || result[W-1] == a_l[W-1]));
    // R4
    remu_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l == 2'b11 && b_l != '0) |-> (result < b_l));

endmodule

bind rvdiv_unit rvdiv_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_sel   (op_sel),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/tb_rvdiv_unit.sv
module tb_rvdiv_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rvdiv_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .result(result)
    );

    // Reference answer from wide signed integer arithmetic
    function automatic logic [31:0] ref_calc(input logic [1:0] op,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
        longint sa, sb, q, r;
        if (op[0]) begin
            sa = longint'({32'b0, a});
            sb = longint'({32'b0, b});
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
        end
        if (sb == 0) begin
            q = -1;
            r = sa;
        end else begin
            q = sa / sb;
            r = sa % sb;
        end
        return op[1] ? r[31:0] : q[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] op, input logic [31:0] a,
                                     input logic [31:0] b);
        if (b == 0) return "R5";
        if (!op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R6";
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // One operation, compared on every clock; optional intruding start (R8)
    task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, input bit intrude);
        logic [31:0] exp;
        logic [31:0] prev;
        string       rq;
        exp  = ref_calc(op, a, b);
        rq   = req_of(op, a, b);
        prev = result;
        @(negedge clk);
        op_sel = op; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = ~a; divisor = b + 32'd3; op_sel = ~op;
        check("R8 busy after accept", {31'b0, busy}, 32'd1);
        for (int k = 2; k <= 34; k++) begin
            if (intrude && k == 10) begin
                start = 1'b1; dividend = 32'd77; divisor = 32'd5;
            end
            @(negedge clk);
            start = 1'b0;
            if (k < 34) begin
                check("R7 done low while running", {31'b0, done}, 32'd0);
                check("R7 result held", result, prev);
            end else begin
                check("R7 done at latency", {31'b0, done}, 32'd1);
                check("R8 busy low at done", {31'b0, busy}, 32'd0);
                check(rq, result, exp);
            end
        end
        @(negedge clk);
        check("R7 done single cycle", {31'b0, done}, 32'd0);
        check("R7 result held after done", result, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", {31'b0, busy}, 32'd0);
        check("R9 done", {31'b0, done}, 32'd0);
        check("R9 result", result, 32'd0);
        rst_n = 1'b1;

        run_op(2'b00, 32'd100, 32'd7, 1'b0);                 // R1
        run_op(2'b00, 32'hFFFF_FF9C, 32'd7, 1'b0);           // R1 -100/7
        run_op(2'b00, 32'd100, 32'hFFFF_FFF9, 1'b0);         // R1 100/-7
        run_op(2'b01, 32'hFFFF_FF9C, 32'd7, 1'b0);           // R2
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);   // R2
        run_op(2'b10, 32'hFFFF_FF9C, 32'd7, 1'b0);           // R3
        run_op(2'b10, 32'd100, 32'hFFFF_FFF9, 1'b0);         // R3
        run_op(2'b11, 32'hFFFF_FF9C, 32'd7, 1'b0);           // R4
        run_op(2'b11, 32'd5, 32'd9, 1'b0);                   // R4
        run_op(2'b00, 32'hFFFF_FF9C, 32'd0, 1'b0);           // R5
        run_op(2'b01, 32'd1234, 32'd0, 1'b0);                // R5
        run_op(2'b10, 32'hFFFF_FF9C, 32'd0, 1'b0);           // R5
        run_op(2'b11, 32'd1234, 32'd0, 1'b0);                // R5
        run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);   // R6
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);   // R6
        run_op(2'b01, 32'd1000, 32'd3, 1'b1);                // R8 ignored start
        for (int i = 0; i < 40; i++)
            run_op(2'($urandom), $urandom, (i % 3 == 0) ? ($urandom & 32'hFF) : $urandom, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule